// File: doc/BRIEF.md
# Decorated Address Bit Manipulation Engine

This block sits between a simple bus master and a peripheral register slave. Spare upper address bits of each access can carry an operation code and its bit or field parameters. When such a decorated access targets the peripheral window, the block turns it into an uninterruptible read-modify-write on the slave register. While that sequence runs, the master is held.

Stores can AND, OR or XOR the write data into the register, or insert a bitfield. Loads can clear one bit and return the old value, set one bit and return the old value, or extract a bitfield. Any access that is not decorated, or whose cleaned address lies outside the window, is passed straight through with its address unchanged. Byte, halfword and word sizes are supported. Data is right-justified on both buses, so bit and field positions count from bit 0 of the accessed unit.

Top module: `bit_manip_engine`

## Requirements
- R1: An access is decorated only if its address, with bits [28:19] cleared, lies in [0x40000000, 0x40070000), and it carries a valid operation. Every other access goes straight to the slave with the original address, and the master gets the slave's ready and read data in the same cycle.
- R2: A store with bit 28 = 0 and bits [27:26] = 01 writes old AND data back to the register.
- R3: A store with bit 28 = 0 writes old OR data back when bits [27:26] = 10, and old XOR data back when they are 11.
- R4: A load with bit 28 = 0 and bits [27:26] = 10 returns the old unit value and then writes it back with the bit selected by address bits [25:21] cleared.
- R5: A load with bit 28 = 0 and bits [27:26] = 11 returns the old unit value and then writes it back with the bit selected by bits [25:21] set.
- R6: A load with bit 28 = 1 returns the field right-justified and zero-extended. The field's lowest bit is at address bits [27:23], and its width minus one is in bits [22:19]. The register keeps its value.
- R7: A store with bit 28 = 1 replaces only the field's bits with the low bits of the write data. All other bits are unchanged.
- R8: Size code 0 selects a byte, 1 a halfword, and 2 or 3 a word. Operations act only on the low 8, 16 or 32 bits of the unit, and bits above the unit are never altered.
- R9: A decorated access reaches the slave as exactly one read followed directly by one write, with no other slave access between them. The master's ready stays low until it pulses high for one cycle at completion.
- R10: The slave address of every decorated read and write is the incoming address with bits [28:19] cleared.
- R11: A clear-bit or set-bit load whose bit index is not below the unit width raises the error output with the completion pulse. It still returns the old value, and no write is issued.
- R12: A bitfield that runs past the top of the accessed unit is truncated there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request, held until m_ready |
| m_we | input | 1 | Master write (store) when 1 |
| m_addr | input | 32 | Master address, possibly decorated |
| m_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| m_wdata | input | 32 | Right-justified store data |
| m_rdata | output | 32 | Right-justified load data |
| m_ready | output | 1 | Transfer completes in this cycle |
| m_err | output | 1 | Bit index out of range, valid with m_ready |
| s_req | output | 1 | Slave request |
| s_we | output | 1 | Slave write |
| s_addr | output | 32 | Slave address |
| s_size | output | 2 | Slave access size |
| s_wdata | output | 32 | Slave write data |
| s_rdata | input | 32 | Slave read data |
| s_ready | input | 1 | Slave completes access |

## Verification
The assertions assume the master keeps m_req and its address, size and data stable until m_ready. They also assume the slave answers each request with ready after a bounded wait. The bench drives every transfer from one task that holds all master inputs until the completion pulse. Its slave model inserts periodic wait states and always returns ready within four cycles. Sweeps cover every bit index at every size and a spread of field positions and widths, including out-of-range and truncated cases.

// File: rtl/bit_manip_engine.sv
module bit_manip_engine #(
  parameter int          AW     = 32,
  parameter int          DW     = 32,
  parameter logic [31:0] WIN_LO = 32'h4000_0000,
  parameter logic [31:0] WIN_HI = 32'h4007_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [1:0]    m_size,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] m_rdata,
  output logic          m_ready,
  output logic          m_err,
  output logic          s_req,
  output logic          s_we,
  output logic [AW-1:0] s_addr,
  output logic [1:0]    s_size,
  output logic [DW-1:0] s_wdata,
  input  logic [DW-1:0] s_rdata,
  input  logic          s_ready
);

  localparam logic [AW-1:0] DECO_BITS = AW'(32'h1FF8_0000);

  typedef enum logic [1:0] {IDLE, RD, WR, DONE} st_t;
  st_t st;

  logic [AW-1:0] base;
  logic          in_win, deco;
  assign base   = m_addr & ~DECO_BITS;
  assign in_win = (base >= AW'(WIN_LO)) && (base < AW'(WIN_HI));
  assign deco   = in_win && (m_addr[28] || (m_we ? (m_addr[27:26] != 2'b00) : m_addr[27]));

  function automatic logic [DW-1:0] unit_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return DW'(32'h0000_00FF);
      2'd1:    return DW'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [5:0] unit_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  logic [AW-1:0] q_addr;
  logic [1:0]    q_size;
  logic [DW-1:0] q_wdata, q_old, q_res;
  logic          q_we, q_bf, q_err;
  logic [1:0]    q_op;
  logic [4:0]    q_lsb, q_bit;
  logic [3:0]    q_wm1;

  logic [DW-1:0] um, wmask, fmask, old_u, new_u, extract;
  logic          bit_err_in;

  assign um      = unit_mask(q_size);
  assign wmask   = (DW'(1) << ({2'b00, q_wm1} + 6'd1)) - DW'(1);
  assign fmask   = (wmask << q_lsb) & um;
  assign old_u   = s_rdata & um;
  assign extract = (old_u & fmask) >> q_lsb;
  assign bit_err_in = !m_addr[28] && !m_we && ({1'b0, m_addr[25:21]} >= unit_bits(m_size));

  always_comb begin
    new_u = q_old;
    if (q_bf) begin
      if (q_we) new_u = (q_old & ~fmask) | ((q_wdata << q_lsb) & fmask);
    end else if (q_we) begin
      case (q_op)
        2'b01:   new_u = q_old & q_wdata;
        2'b10:   new_u = q_old | q_wdata;
        default: new_u = q_old ^ q_wdata;
      endcase
    end else if (q_op == 2'b10) begin
      new_u = q_old & ~(DW'(1) << q_bit);
    end else begin
      new_u = q_old | (DW'(1) << q_bit);
    end
    new_u = new_u & um;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      q_addr  <= '0;
      q_size  <= '0;
      q_wdata <= '0;
      q_old   <= '0;
      q_res   <= '0;
      q_we    <= 1'b0;
      q_bf    <= 1'b0;
      q_err   <= 1'b0;
      q_op    <= '0;
      q_lsb   <= '0;
      q_bit   <= '0;
      q_wm1   <= '0;
    end else begin
      case (st)
        IDLE: if (m_req && deco) begin
          st      <= RD;
          q_addr  <= base;
          q_size  <= m_size;
          q_wdata <= m_wdata & unit_mask(m_size);
          q_we    <= m_we;
          q_bf    <= m_addr[28];
          q_op    <= m_addr[27:26];
          q_lsb   <= m_addr[27:23];
          q_wm1   <= m_addr[22:19];
          q_bit   <= m_addr[25:21];
          q_err   <= bit_err_in;
        end
        RD: if (s_ready) begin
          q_old <= old_u;
          if (q_we)      q_res <= '0;
          else if (q_bf) q_res <= extract;
          else           q_res <= old_u;
          st <= q_err ? DONE : WR;
        end
        WR:      if (s_ready) st <= DONE;
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    s_req   = 1'b0;
    s_we    = 1'b0;
    s_addr  = q_addr;
    s_size  = q_size;
    s_wdata = new_u;
    m_ready = 1'b0;
    m_rdata = q_res;
    m_err   = 1'b0;
    case (st)
      IDLE: begin
        s_req   = m_req && !deco;
        s_we    = m_we;
        s_addr  = m_addr;
        s_size  = m_size;
        s_wdata = m_wdata;
        m_ready = m_req && !deco && s_ready;
        m_rdata = s_rdata;
      end
      RD: s_req = 1'b1;
      WR: begin
        s_req = 1'b1;
        s_we  = 1'b1;
      end
      default: begin
        m_ready = 1'b1;
        m_err   = q_err;
      end
    endcase
  end

  a_r9_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RD || st == WR) |-> !m_ready);
  a_r9_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RD && s_ready && !q_err) |=> (s_req && s_we));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DONE) |=> (st == IDLE));
  a_r10_clean_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && st != IDLE) |-> (s_addr[28:19] == 10'd0));
  a_r11_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> m_ready);
  a_r11_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RD && s_ready && q_err) |=> !s_req);
  a_r1_passthrough_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && s_req) |-> (s_addr == m_addr));

endmodule

// File: tb/tb_bit_manip_engine.sv
module tb_bit_manip_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_req = 1'b0, m_we = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [1:0]  m_size = '0;
  logic [31:0] m_rdata, s_addr, s_wdata, s_rdata;
  logic m_ready, m_err, s_req, s_we, s_ready;
  logic [1:0] s_size;

  always #4 clk = ~clk;

  bit_manip_engine dut (.*);

  logic [31:0] mem [8];
  logic [31:0] last_waddr;
  int n_rd = 0, n_wr = 0, cyc = 0;
  int checks = 0, fails = 0;

  function automatic logic [31:0] um(input logic [1:0] sz);
    return sz == 2'd0 ? 32'hFF : sz == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign s_ready = (cyc % 4) != 1;
  assign s_rdata = mem[s_addr[4:2]] & um(s_size);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (s_req && s_ready) begin
      if (s_we) begin
        mem[s_addr[4:2]] <= (mem[s_addr[4:2]] & ~um(s_size)) | (s_wdata & um(s_size));
        last_waddr <= s_addr;
        n_wr <= n_wr + 1;
      end else n_rd <= n_rd + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] rd;
  logic        er;
  int          lat;

  task automatic xfer(input bit we, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_addr = a; m_size = sz; m_wdata = wd;
    lat = 0;
    forever begin
      #1;
      if (m_ready) break;
      @(negedge clk);
      lat++;
    end
    rd = m_rdata; er = m_err;
    @(posedge clk); #1;
    m_req = 1'b0;
  endtask

  localparam logic [31:0] REG = 32'h4000_1004;

  task automatic put(input logic [31:0] v);
    xfer(1'b1, REG, 2'd2, v);
  endtask

  task automatic get_chk(input logic [31:0] exp, input string req);
    xfer(1'b0, REG, 2'd2, 32'h0);
    check(rd === exp, req, rd, exp);
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 32'h0;
    #1;
    check(m_ready === 1'b0 && s_req === 1'b0, "R9 reset", {30'd0, m_ready, s_req}, 32'h0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 plain accesses and out-of-window decoration
    put(32'h1234_5678);
    get_chk(32'h1234_5678, "R1 plain word");
    check(lat == 0 || lat == 1, "R1 passthrough latency", lat, 0);
    xfer(1'b1, 32'h4007_1004 | (32'h1 << 26), 2'd2, 32'h0F0F_0F0F);
    check(last_waddr === (32'h4007_1004 | (32'h1 << 26)), "R1 outside window addr", last_waddr, 32'h4407_1004);
    xfer(1'b0, 32'h4000_1004, 2'd2, 0);
    check(rd === 32'h0F0F_0F0F, "R1 outside window plain write", rd, 32'h0F0F_0F0F);

    // R2 R3 R8 logical stores
    for (int sz = 0; sz < 3; sz++) begin
      for (int op = 1; op < 4; op++) begin
        logic [31:0] pat, wd, u, nu, expw;
        int r0, w0;
        pat = 32'hC3A5_96F0 ^ (op * 32'h1111_1111);
        wd  = 32'h5AF0_3C69 + sz;
        put(pat);
        u = pat & um(2'(sz));
        nu = op == 1 ? (u & wd) : op == 2 ? (u | wd) : (u ^ wd);
        expw = (pat & ~um(2'(sz))) | (nu & um(2'(sz)));
        r0 = n_rd; w0 = n_wr;
        xfer(1'b1, REG | (32'(op) << 26), 2'(sz), wd);
        check(n_rd - r0 == 1 && n_wr - w0 == 1 && lat >= 2, "R9 one read one write", lat, 2);
        check(last_waddr === REG, "R10 clean address", last_waddr, REG);
        get_chk(expw, op == 1 ? "R2 AND store R8" : "R3 OR/XOR store R8");
      end
    end

    // R4 R5 R11 R8 single-bit loads, every index at every size
    for (int sz = 0; sz < 3; sz++) begin
      for (int las = 0; las < 2; las++) begin
        for (int b = 0; b < 32; b++) begin
          logic [31:0] pat, u, expw;
          int w0, nb;
          nb = sz == 0 ? 8 : sz == 1 ? 16 : 32;
          pat = las ? 32'h3C5A_A5C3 : 32'hA5C3_5A3C;
          put(pat);
          u = pat & um(2'(sz));
          w0 = n_wr;
          xfer(1'b0, REG | (las ? 32'h0C00_0000 : 32'h0800_0000) | (32'(b) << 21), 2'(sz), 0);
          check(rd === u, las ? "R5 LAS old value" : "R4 LAC old value", rd, u);
          if (b >= nb) begin
            check(er === 1'b1 && n_wr == w0, "R11 index error, no write", {31'd0, er}, 32'h1);
            expw = pat;
          end else begin
            check(er === 1'b0, "R11 no error in range", {31'd0, er}, 32'h0);
            expw = las ? (pat | (32'h1 << b)) : (pat & ~(32'h1 << b));
          end
          get_chk(expw, las ? "R5 LAS result R8" : "R4 LAC result R8");
        end
      end
    end

    // R6 R7 R12 bitfield
    for (int sz = 0; sz < 3; sz++) begin
      for (int lsb = 0; lsb < 32; lsb += 5) begin
        for (int w = 1; w <= 16; w += 3) begin
          logic [31:0] pat, fm, ex, wd, expw;
          logic [31:0] a;
          pat = 32'h9E37_79B9 ^ (32'(lsb) * 32'h0101_0101);
          wd  = 32'h0000_A5A5 ^ 32'(w);
          fm = (((32'h1 << w) - 1) << lsb) & um(2'(sz));
          ex = (pat & fm) >> lsb;
          a = REG | 32'h1000_0000 | (32'(lsb) << 23) | (32'(w - 1) << 19);
          put(pat);
          xfer(1'b0, a, 2'(sz), 0);
          check(rd === ex, (lsb + w > 8 * (1 << sz)) ? "R12 truncated extract" : "R6 extract", rd, ex);
          get_chk(pat, "R6 register unchanged");
          xfer(1'b1, a, 2'(sz), wd);
          expw = (pat & ~fm) | ((wd << lsb) & fm);
          get_chk(expw, (lsb + w > 8 * (1 << sz)) ? "R12 truncated insert" : "R7 insert");
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule